// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port with Interrupt Flags

This block is the bus-facing register file of a real-time clock. Software sees two byte addresses. The even address holds a 7-bit pointer into a 128-byte space. The odd address reads or writes the byte that the pointer selects. Four control bytes in that space have special behaviour:

- the rate/divider byte (index 0x0A);
- the enable/mode byte (index 0x0B);
- the event status byte (index 0x0C);
- the constant validity byte (index 0x0D).

Every other index is an ordinary storage byte.

The periodic unit and the update/alarm unit sit next to this block and send single-cycle set pulses. Those pulses land in the status byte. A summary bit in that byte drives the interrupt line. The block applies the enables, read-to-clear, read-only fields and power-up values. The status byte is also re-checked at the moment software changes the enables. The rate byte and the enable byte are exported so that the timing units can use them.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (bus_addr=0) loads bits 6:0 of the data into the index, and bit 7 is dropped. A read of the even address returns 0xFF.
- R2: A write to the odd address (bus_addr=1) stores the byte at the current index. A later odd read at that index returns it. This holds for every index other than 0x0A to 0x0D.
- R3: Writes to the status byte (index 0x0C) and to the validity byte (index 0x0D) are ignored. The validity byte always reads 0x80.
- R4: Bit 7 of the rate byte (index 0x0A) reads the live uip_in input. A write to that byte stores only bits 6:0.
- R5: An odd read at index 0x0C returns the current status byte. At the next clock edge the whole byte clears and irq goes low.
- R6: The status byte layout is as follows:
  - pf_set sets bit 6, af_set sets bit 5 and uf_set sets bit 4.
  - A pulse also sets the summary bit 7, and raises irq on the next cycle, only when its enable in the enable byte is 1. The enables are bit 6 for periodic, bit 5 for alarm and bit 4 for update.
  - irq always equals status bit 7.
- R7: When the enable byte (index 0x0B) is written, the summary bit and irq are re-evaluated from scratch. They are set when a written bit 6:4 matches a flag that is already set, and cleared otherwise. A flag pulse in that same cycle is judged against the newly written enables.
- R8: A flag pulse in the same cycle as a status read is kept. The flag is set after the clear, and so is the summary bit if that flag is enabled.
- R9: After power-up reset, the values are:
  - index = 0;
  - rate byte = 0x26;
  - enable byte = 0x02;
  - status byte = 0x00, with irq low;
  - storage bytes = 0x00.
- R10: soft_clr has the following effects:
  - It clears bits 6, 5 and 3 of the enable byte.
  - It clears the whole status byte and drops irq.
  - It takes precedence over a same-cycle write to the enable byte and over same-cycle flag pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| soft_clr | input | 1 | System reset pulse: clears enables and flags |
| bus_wr | input | 1 | Write strobe (takes precedence over bus_rd) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address and index |
| uip_in | input | 1 | Update-in-progress level from the timekeeping unit |
| pf_set | input | 1 | Periodic event pulse |
| af_set | input | 1 | Alarm event pulse |
| uf_set | input | 1 | Update-ended event pulse |
| ctrl_a | output | 8 | Rate byte as read (bit 7 = uip_in) |
| ctrl_b | output | 8 | Enable/mode byte |
| irq | output | 1 | Interrupt request, equal to status bit 7 |

## Verification
The bench first runs directed sequences:

- A pulse with its enable off versus on tells flag-only capture apart from interrupt raising.
- An enable write made after the flag is already pending, and then one with a non-matching enable, tells the write-time re-evaluation apart from plain latching.
- A status read that coincides with a pulse separates the read-clear from the set path.

A long pseudo-random mix of index moves, reads, writes, pulses, uip levels and rare soft clears is then compared every cycle against a behavioural model. This exposes ordering faults that the directed cases miss.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0] IDX_RATE   = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_ENAB   = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_STAT   = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_VALID  = 7'h0D;

  localparam logic [DATA_W-2:0] RATE_INIT  = 7'h26;
  localparam logic [DATA_W-1:0] ENAB_INIT  = 8'h02;
  localparam logic [DATA_W-1:0] VALID_VAL  = 8'h80;
  // enable bits dropped by a soft clear: periodic(6), alarm(5), square wave(3)
  localparam logic [DATA_W-1:0] ENAB_CLR   = 8'h68;
  localparam logic [DATA_W-1:0] IDX_PORT_RD = 8'hFF;

  // flag order in every 3-bit vector: {periodic, alarm, update} = bits 6:4
  localparam int FLAG_LO = 4;
  localparam int FLAG_HI = 6;
  localparam int SUM_BIT = 7;

  function automatic logic enable_hit(input logic [2:0] en, input logic [2:0] flags);
    return |(en & flags);
  endfunction

  function automatic logic is_ctrl_idx(input logic [IDX_W-1:0] idx);
    return (idx >= IDX_RATE) && (idx <= IDX_VALID);
  endfunction
endpackage

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_regport_pkg::*;
#(
  parameter int AW = IDX_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R2: a stored byte reads back on the following cycle at the same index
  a_r2_store_readback: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (($past(addr) != addr) || (rdata == $past(wdata))));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_rate,
  input  logic              wr_enab,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-2:0] rate_q,
  output logic [DATA_W-1:0] enab_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_INIT;
    end else if (wr_rate) begin
      rate_q <= wdata[DATA_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= ENAB_INIT;
    end else if (soft_clr) begin
      enab_q <= enab_q & ~ENAB_CLR;
    end else if (wr_enab) begin
      enab_q <= wdata;
    end
  end

  // R10: soft clear leaves the dropped enables low
  a_r10_enables_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ((enab_q & ENAB_CLR) == '0));

  // R4: the stored rate bits change only through a write
  a_r4_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rate |=> $stable(rate_q));
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              rd_stat,
  input  logic              wr_enab,
  input  logic [2:0]        wr_en_bits,
  input  logic [2:0]        cur_en_bits,
  input  logic [2:0]        flag_set,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);
  logic [2:0] flags_q, flags_n;
  logic       sum_q, sum_n;
  logic [2:0] en_eff;
  logic       pulse_hit;

  assign en_eff    = wr_enab ? wr_en_bits : cur_en_bits;
  assign pulse_hit = enable_hit(en_eff, flag_set);

  always_comb begin
    flags_n = flags_q;
    sum_n   = sum_q;
    if (rd_stat) begin
      flags_n = '0;
      sum_n   = 1'b0;
    end
    if (wr_enab) sum_n = enable_hit(wr_en_bits, flags_q);
    flags_n = flags_n | flag_set;
    if (pulse_hit) sum_n = 1'b1;
    if (soft_clr) begin
      flags_n = '0;
      sum_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      sum_q   <= sum_n;
    end
  end

  assign stat_q = {sum_q, flags_q, 4'b0000};
  assign irq    = sum_q;

  // R5: a read with no coincident pulse empties the byte and drops irq
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !soft_clr && flag_set == 3'b000) |=> (stat_q == '0 && !irq));

  // R6: an enabled pulse raises irq on the next cycle
  a_r6_enabled_pulse_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_hit && !soft_clr) |=> irq);

  // R6: without a read, enable write, soft clear or enabled pulse, irq holds
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_hit && !wr_enab && !rd_stat && !soft_clr) |=> (irq == $past(irq)));

  // R7: enable write re-evaluates against flags already pending
  a_r7_enable_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enab && !soft_clr && flag_set == 3'b000) |=>
      (irq == |($past(wr_en_bits) & $past(flags_q))));

  // R8: a pulse coincident with a read survives the clear
  a_r8_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !soft_clr) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  // R10: soft clear empties the status byte
  a_r10_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (stat_q == '0 && !irq));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uip_in,
  input  logic              pf_set,
  input  logic              af_set,
  input  logic              uf_set,
  output logic [DATA_W-1:0] ctrl_a,
  output logic [DATA_W-1:0] ctrl_b,
  output logic              irq
);
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-2:0] rate_q;
  logic [DATA_W-1:0] enab_q, stat_q, store_rd;
  logic              do_rd, idx_we, data_we;
  logic              wr_rate, wr_enab, wr_stat, store_we, rd_stat;
  logic [2:0]        flag_set;

  assign do_rd    = bus_rd & ~bus_wr;
  assign idx_we   = bus_wr & ~bus_addr;
  assign data_we  = bus_wr & bus_addr;
  assign wr_rate  = data_we && (idx_q == IDX_RATE);
  assign wr_enab  = data_we && (idx_q == IDX_ENAB);
  assign wr_stat  = data_we && (idx_q == IDX_STAT);
  assign store_we = data_we && !is_ctrl_idx(idx_q);
  assign rd_stat  = do_rd && bus_addr && (idx_q == IDX_STAT);
  assign flag_set = {pf_set, af_set, uf_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= bus_wdata[IDX_W-1:0];
  end

  rtc_store #(.AW(IDX_W), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .addr  (idx_q),
    .wdata (bus_wdata),
    .rdata (store_rd)
  );

  rtc_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .wr_rate  (wr_rate),
    .wr_enab  (wr_enab),
    .wdata    (bus_wdata),
    .rate_q   (rate_q),
    .enab_q   (enab_q)
  );

  rtc_flag_unit u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_clr    (soft_clr),
    .rd_stat     (rd_stat),
    .wr_enab     (wr_enab),
    .wr_en_bits  (bus_wdata[FLAG_HI:FLAG_LO]),
    .cur_en_bits (enab_q[FLAG_HI:FLAG_LO]),
    .flag_set    (flag_set),
    .stat_q      (stat_q),
    .irq         (irq)
  );

  always_comb begin
    if (!bus_addr) begin
      bus_rdata = IDX_PORT_RD;
    end else begin
      unique case (idx_q)
        IDX_RATE:  bus_rdata = {uip_in, rate_q};
        IDX_ENAB:  bus_rdata = enab_q;
        IDX_STAT:  bus_rdata = stat_q;
        IDX_VALID: bus_rdata = VALID_VAL;
        default:   bus_rdata = store_rd;
      endcase
    end
  end

  assign ctrl_a = {uip_in, rate_q};
  assign ctrl_b = enab_q;

  // R3: a bus write to the status byte alone leaves it unchanged
  a_r3_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && flag_set == 3'b000 && !soft_clr) |=> $stable(stat_q));

  // R1: index register follows only even-address writes
  a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));
endmodule

// File: tb/rtc_regport_bench.sv
module rtc_regport_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_clr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, ctrl_a, ctrl_b;
  logic       uip_in = 1'b0, pf_set = 1'b0, af_set = 1'b0, uf_set = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;

  rtc_regport u_rtc_regport (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uip_in(uip_in),
    .pf_set(pf_set), .af_set(af_set), .uf_set(uf_set),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // behavioural model state
  logic [6:0] m_idx;
  logic [6:0] m_rate;
  logic [7:0] m_enab;
  logic [2:0] m_fl;
  logic       m_sum;
  logic [7:0] m_mem [128];
  logic [7:0] last_rd;

  task automatic check(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input bit up);
    case (m_idx)
      7'h0A:   return {up, m_rate};
      7'h0B:   return m_enab;
      7'h0C:   return {m_sum, m_fl, 4'h0};
      7'h0D:   return 8'h80;
      default: return m_mem[m_idx];
    endcase
  endfunction

  task automatic model_step(input bit wr, input bit rd, input bit ad,
                            input logic [7:0] wd, input logic [2:0] fs, input bit sc);
    bit         odd_wr = wr && ad;
    bit         stat_rd = rd && !wr && ad && (m_idx == 7'h0C);
    logic [2:0] en;
    logic [2:0] fl_n;
    logic       sum_n;
    en = (odd_wr && m_idx == 7'h0B) ? wd[6:4] : m_enab[6:4];
    if (sc) begin
      fl_n = 3'b000; sum_n = 1'b0;
    end else begin
      fl_n = m_fl; sum_n = m_sum;
      if (stat_rd) begin fl_n = 3'b000; sum_n = 1'b0; end
      if (odd_wr && m_idx == 7'h0B) sum_n = ((wd[6:4] & m_fl) != 3'b000);
      fl_n = fl_n | fs;
      if ((fs & en) != 3'b000) sum_n = 1'b1;
    end
    m_fl = fl_n; m_sum = sum_n;
    if (sc) m_enab = m_enab & 8'h97;
    else if (odd_wr && m_idx == 7'h0B) m_enab = wd;
    if (odd_wr && m_idx == 7'h0A) m_rate = wd[6:0];
    if (odd_wr && (m_idx < 7'h0A || m_idx > 7'h0D)) m_mem[m_idx] = wd;
    if (wr && !ad) m_idx = wd[6:0];
  endtask

  task automatic op(input string tag, input bit wr, input bit rd, input bit ad,
                    input logic [7:0] wd, input logic [2:0] fs, input bit sc, input bit up);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = ad; bus_wdata = wd;
    {pf_set, af_set, uf_set} = fs; soft_clr = sc; uip_in = up;
    #1;
    check(tag, "irq", {7'b0, irq}, {7'b0, m_sum});
    check(tag, "ctrl_b", ctrl_b, m_enab);
    if (rd && !wr) begin
      last_rd = bus_rdata;
      check(tag, "rdata", bus_rdata, ad ? model_read(up) : 8'hFF);
    end
    model_step(wr, rd, ad, wd, fs, sc);
  endtask

  task automatic set_idx(input string tag, input logic [7:0] v);
    op(tag, 1, 0, 0, v, 3'b000, 0, 0);
  endtask

  task automatic wr_odd(input string tag, input logic [7:0] v);
    op(tag, 1, 0, 1, v, 3'b000, 0, 0);
  endtask

  task automatic rd_odd(input string tag, input logic [7:0] exp, input bit up);
    op(tag, 0, 1, 1, 8'h00, 3'b000, 0, up);
    check(tag, "value", last_rd, exp);
  endtask

  task automatic pulse(input string tag, input logic [2:0] fs);
    op(tag, 0, 0, 0, 8'h00, fs, 0, 0);
  endtask

  task automatic chk_irq(input string tag, input bit exp);
    @(posedge clk);
    #1;
    check(tag, "irq level", {7'b0, irq}, {7'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    m_idx = '0; m_rate = 7'h26; m_enab = 8'h02; m_fl = '0; m_sum = 1'b0;
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 power-up values
    chk_irq("R9", 1'b0);
    set_idx("R9", 8'h0A); rd_odd("R9", 8'h26, 0);
    set_idx("R9", 8'h0B); rd_odd("R9", 8'h02, 0);
    set_idx("R9", 8'h0C); rd_odd("R9", 8'h00, 0);
    set_idx("R9", 8'h0D); rd_odd("R9", 8'h80, 0);
    set_idx("R9", 8'h20); rd_odd("R9", 8'h00, 0);

    // R1 index port, R2 storage
    op("R1", 0, 1, 0, 8'h00, 3'b000, 0, 0);
    check("R1", "even read", last_rd, 8'hFF);
    set_idx("R1", 8'hA0); wr_odd("R2", 8'h5A); rd_odd("R1", 8'h5A, 0);
    set_idx("R2", 8'h7F); wr_odd("R2", 8'hC3); rd_odd("R2", 8'hC3, 0);
    set_idx("R2", 8'h20); rd_odd("R2", 8'h5A, 0);

    // R4 read-only update bit
    set_idx("R4", 8'h0A); rd_odd("R4", 8'hA6, 1);
    wr_odd("R4", 8'hFF); rd_odd("R4", 8'h7F, 0); rd_odd("R4", 8'hFF, 1);
    wr_odd("R4", 8'h26);

    // R3 write-ignored bytes
    set_idx("R3", 8'h0C); wr_odd("R3", 8'hFF); rd_odd("R3", 8'h00, 0);
    chk_irq("R3", 1'b0);
    set_idx("R3", 8'h0D); wr_odd("R3", 8'h00); rd_odd("R3", 8'h80, 0);

    // R6 flag capture with and without enable; R5 read clear
    set_idx("R6", 8'h0C); pulse("R6", 3'b100); chk_irq("R6", 1'b0);
    rd_odd("R6", 8'h40, 0); rd_odd("R5", 8'h00, 0);
    set_idx("R6", 8'h0B); wr_odd("R6", 8'h42); set_idx("R6", 8'h0C);
    pulse("R6", 3'b100); chk_irq("R6", 1'b1);
    rd_odd("R5", 8'hC0, 0); chk_irq("R5", 1'b0);

    // R7 enable write re-evaluation
    set_idx("R7", 8'h0B); wr_odd("R7", 8'h02);
    pulse("R7", 3'b010); chk_irq("R7", 1'b0);
    wr_odd("R7", 8'h22); chk_irq("R7", 1'b1);
    wr_odd("R7", 8'h42); chk_irq("R7", 1'b0);
    pulse("R7", 3'b001); wr_odd("R7", 8'h12); chk_irq("R7", 1'b1);
    set_idx("R7", 8'h0C); rd_odd("R7", 8'hB0, 0); chk_irq("R7", 1'b0);

    // R8 pulse coincident with status read
    op("R8", 0, 1, 1, 8'h00, 3'b001, 0, 0);
    check("R8", "value", last_rd, 8'h00);
    chk_irq("R8", 1'b1);
    rd_odd("R8", 8'h90, 0);

    // R10 soft clear
    set_idx("R10", 8'h0B); wr_odd("R10", 8'h7A);
    pulse("R10", 3'b111); chk_irq("R10", 1'b1);
    op("R10", 0, 0, 0, 8'h00, 3'b111, 1, 0);
    chk_irq("R10", 1'b0);
    rd_odd("R10", 8'h12, 0);
    set_idx("R10", 8'h0C); rd_odd("R10", 8'h00, 0);

    // mixed traffic against the model (R1..R10)
    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom % 8;
      logic [2:0]  fs = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'b000;
      bit          sc = (($urandom % 64) == 0);
      bit          up = 1'($urandom % 2);
      logic [7:0]  d = 8'($urandom);
      logic [7:0]  ix = (($urandom % 3) == 0) ? (8'h10 + 8'($urandom % 4)) : (8'h0A + 8'($urandom % 4));
      case (r)
        0, 1:    op("MIX", 1, 0, 0, ix | (d & 8'h80), fs, sc, up);
        2, 3:    op("MIX", 0, 1, 1, 8'h00, fs, sc, up);
        4:       op("MIX", 1, 0, 1, d, fs, sc, up);
        5:       op("MIX", 0, 1, 0, 8'h00, fs, sc, up);
        default: op("MIX", 0, 0, 0, 8'h00, fs, sc, up);
      endcase
    end
    op("MIX", 0, 0, 0, 8'h00, 3'b000, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule